// File: doc/BRIEF.md
# Parallel Host Command Interface

This block is the host-facing front end of a dot-matrix display controller. A host processor moves bytes over an 8-bit bus, framing each transfer with a strobe and qualifying it with an enable input. A select input marks a transfer as display data or as a command, and a direction input marks it as a read or a write. The block brings the strobe into the system clock domain and acts once on each falling strobe edge. On that edge it decodes command bytes into a configuration register file, or it forwards display-data writes and reads to the display RAM address controller as one-cycle requests.

Opcodes use a prefix code of variable length. A leading one selects the column address. Shorter prefixes carry the scroll, page, contrast, icon and single-bit option fields. A few fixed bytes raise one-cycle requests to clear RAM or to save or restore the column address. The contrast prefix works in both directions: written, it loads the contrast level; read, it returns that level. A separate opcode steps the contrast up or down by one level and wraps at either end. The bias, pump and regulator enables are only stored here and fed to the analog blocks.

The bus is split into an input byte, an output byte and an output enable. The pad ring joins them into the bidirectional pins.

Top module: `hcif_host_port`

## Requirements
- R1: After reset every configuration field reads 0, except the icon contrast field, which reads 2'b10. No request output is high and the bus output enable is low.
- R2: A transfer takes effect only on a falling edge of the strobe while the enable input is high. A strobe pulse with enable low changes no register and raises no request.
- R3: A write with select high (data) raises `ram_wr_req` for exactly one cycle and presents the bus byte on `ram_wr_byte`. The configuration is left unchanged.
- R4: A read with select high (data) drives `ram_rd_byte` on `hst_dout` while the strobe is high. After the falling edge it raises `ram_rd_req` for one cycle, and the configuration is left unchanged.
- R5: `hst_oe` is high only while enable, read and strobe are all high. At all other times it is low.
- R6: A read with select low (command) drives `{4'b0001, contrast}` on `hst_dout` and changes no register.
- R7: Command `00000ppp` loads the page field with ppp when ppp is 0 to 4. Codes 5 to 7 are ignored.
- R8: Command `0001cccc` loads the 4-bit contrast. Command `0111000x` steps it down (x=0) or up (x=1) by one, wrapping between 15 and 0.
- R9: Command `1ccccccc` loads the 7-bit column field. Command `010sssss` loads the 5-bit scroll field.
- R10: Command `01100aax` sets icon bit aa to x. Command `000011cc` loads the 2-bit icon contrast.
- R11: Single-bit options are set to x by these opcodes: doubler `0010000x`, column mirror `0010001x`, row mirror `0010010x`, display on `0010100x`, pump on `0010101x`, regulator on `0010110x`, divider on `0010111x`, contrast control on `0011000x`, fast clock `0011001x`, fifth bias `0011100x`, half duty `0110100x`, oscillator on `0111111x`.
- R12: `00110110` pulses `clr_main_req`, `00110111` pulses `clr_icon_req`, `00110101` pulses `col_save_req` and `00110100` pulses `col_restore_req`, each for one cycle.
- R13: Every other command byte, such as `0010011x`, `00111xxx` outside the bias code, `0110101x`, `01110010` or `00001000`, changes no register and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_strobe | input | 1 | Host strobe; the transfer is taken on its falling edge |
| hst_en | input | 1 | Host enable; qualifies the strobe |
| hst_dsel | input | 1 | 1 = display data, 0 = command |
| hst_rd | input | 1 | 1 = read, 0 = write |
| hst_din | input | 8 | Byte from the host bus |
| hst_dout | output | 8 | Byte driven onto the host bus |
| hst_oe | output | 1 | Bus output enable |
| ram_rd_byte | input | 8 | Read byte from the display RAM controller |
| ram_wr_req | output | 1 | One-cycle display-data write request |
| ram_wr_byte | output | 8 | Byte belonging to the last write request |
| ram_rd_req | output | 1 | One-cycle display-data read request |
| clr_main_req | output | 1 | Request to clear pages 1 to 4 |
| clr_icon_req | output | 1 | Request to clear page 5 |
| col_save_req | output | 1 | Request to save the column address |
| col_restore_req | output | 1 | Request to restore the column address |
| page_sel | output | 3 | Page field, 0 to 4 |
| column_sel | output | 7 | Column field |
| scroll_val | output | 5 | Vertical scroll field |
| contrast_lvl | output | 4 | Contrast level |
| icon_on | output | 4 | Static icon enables |
| icon_contrast | output | 2 | Icon contrast code |
| pump_doubler | output | 1 | Doubler selected instead of tripler |
| col_mirror | output | 1 | Column mapping reversed |
| row_mirror | output | 1 | Row mapping reversed |
| display_on | output | 1 | Display enable |
| dcdc_on | output | 1 | Charge pump enable |
| regulator_on | output | 1 | Regulator enable |
| divider_on | output | 1 | Bias divider enable |
| contrast_ctl_on | output | 1 | Internal contrast control enable |
| clk_fast | output | 1 | Fast display clock selected |
| bias_fifth | output | 1 | 1/5 bias selected (0 = 1/7) |
| duty_half | output | 1 | Half-duty scan selected (0 = full) |
| osc_on | output | 1 | Oscillator enable |

## Verification
The bench targets the contrast wrap at both ends. A design that saturates instead of wrapping would keep 15 after a step up, or 0 after a step down. It writes page codes 5 to 7 and a set of reserved bytes that lie next to valid prefixes. A decoder with too loose a match would load a field or raise a clear request from one of them. It pulses the strobe with enable low and reads data and commands with enable toggled. A design that drives the bus or acts on an unqualified strobe shows either a wrong `hst_oe` or a changed register. It also checks that each request lasts one cycle and that data transfers leave the configuration untouched.

// File: rtl/hcif_pkg.sv
package hcif_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_OPTS = 12;
  localparam int OPT_AW   = $clog2(NUM_OPTS);
  localparam int MAX_PAGE = 4;

  // single-bit option slots
  localparam logic [OPT_AW-1:0] OPT_DOUBLER = 4'd0;
  localparam logic [OPT_AW-1:0] OPT_COLMIR  = 4'd1;
  localparam logic [OPT_AW-1:0] OPT_ROWMIR  = 4'd2;
  localparam logic [OPT_AW-1:0] OPT_DISP    = 4'd3;
  localparam logic [OPT_AW-1:0] OPT_DCDC    = 4'd4;
  localparam logic [OPT_AW-1:0] OPT_REG     = 4'd5;
  localparam logic [OPT_AW-1:0] OPT_DIV     = 4'd6;
  localparam logic [OPT_AW-1:0] OPT_CCTL    = 4'd7;
  localparam logic [OPT_AW-1:0] OPT_FAST    = 4'd8;
  localparam logic [OPT_AW-1:0] OPT_BIAS    = 4'd9;
  localparam logic [OPT_AW-1:0] OPT_DUTY    = 4'd10;
  localparam logic [OPT_AW-1:0] OPT_OSC     = 4'd11;

  typedef enum logic [3:0] {
    OP_NONE, OP_PAGE, OP_CONTRAST, OP_COLUMN, OP_SCROLL, OP_ICON,
    OP_ICON_CTR, OP_OPT, OP_STEP, OP_CLR_MAIN, OP_CLR_ICON,
    OP_SAVE, OP_RESTORE
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [OPT_AW-1:0] opt;
  } dec_t;

  typedef struct packed {
    logic [2:0]          page;
    logic [3:0]          contrast;
    logic [6:0]          column;
    logic [4:0]          scroll;
    logic [3:0]          icons;
    logic [1:0]          ictr;
    logic [NUM_OPTS-1:0] opts;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{page: 3'd0, contrast: 4'd0, column: 7'd0,
                                 scroll: 5'd0, icons: 4'd0, ictr: 2'b10,
                                 opts: '0};

  // prefix-code decode of one command byte
  function automatic dec_t decode_cmd(input logic [BYTE_W-1:0] b);
    dec_t d;
    d.op  = OP_NONE;
    d.opt = '0;
    casez (b)
      8'b1???????: d.op = OP_COLUMN;
      8'b010?????: d.op = OP_SCROLL;
      8'b01100???: d.op = OP_ICON;
      8'b0110100?: begin d.op = OP_OPT; d.opt = OPT_DUTY; end
      8'b0111000?: d.op = OP_STEP;
      8'b0111111?: begin d.op = OP_OPT; d.opt = OPT_OSC; end
      8'b0001????: d.op = OP_CONTRAST;
      8'b00000???: if (int'(b[2:0]) <= MAX_PAGE) d.op = OP_PAGE;
      8'b000011??: d.op = OP_ICON_CTR;
      8'b0010????: begin
        d.op = OP_OPT;
        case (b[3:1])
          3'b000:  d.opt = OPT_DOUBLER;
          3'b001:  d.opt = OPT_COLMIR;
          3'b010:  d.opt = OPT_ROWMIR;
          3'b100:  d.opt = OPT_DISP;
          3'b101:  d.opt = OPT_DCDC;
          3'b110:  d.opt = OPT_REG;
          3'b111:  d.opt = OPT_DIV;
          default: d.op  = OP_NONE;
        endcase
      end
      8'b0011????: begin
        case (b[3:1])
          3'b000:  begin d.op = OP_OPT; d.opt = OPT_CCTL; end
          3'b001:  begin d.op = OP_OPT; d.opt = OPT_FAST; end
          3'b010:  d.op = b[0] ? OP_SAVE : OP_RESTORE;
          3'b011:  d.op = b[0] ? OP_CLR_ICON : OP_CLR_MAIN;
          3'b100:  begin d.op = OP_OPT; d.opt = OPT_BIAS; end
          default: d.op = OP_NONE;
        endcase
      end
      default: d.op = OP_NONE;
    endcase
    return d;
  endfunction

  // wrapping one-level contrast step
  function automatic logic [3:0] contrast_step(input logic [3:0] c, input logic up);
    return up ? c + 4'd1 : c - 4'd1;
  endfunction

endpackage

// File: rtl/hcif_strobe_sync.sv
module hcif_strobe_sync #(
  parameter int STAGES = 2,
  parameter int W      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic         en_i,
  input  logic         dsel_i,
  input  logic         rd_i,
  input  logic [W-1:0] din_i,
  output logic         fall_o,
  output logic         en_o,
  output logic         dsel_o,
  output logic         rd_o,
  output logic [W-1:0] din_o
);
  localparam int PW = W + 4;

  logic [STAGES-1:0][PW-1:0] pipe_q;
  logic                      last_q;
  logic [PW-1:0]             tail;

  assign tail = pipe_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], {strobe_i, en_i, dsel_i, rd_i, din_i}};
      last_q <= tail[PW-1];
    end
  end

  assign fall_o = last_q & ~tail[PW-1];
  assign en_o   = tail[PW-2];
  assign dsel_o = tail[PW-3];
  assign rd_o   = tail[PW-4];
  assign din_o  = tail[W-1:0];

endmodule

// File: rtl/hcif_cmd_decode.sv
module hcif_cmd_decode
  import hcif_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output op_e               op_o,
  output logic [OPT_AW-1:0] opt_o
);
  dec_t d;
  always_comb d = decode_cmd(cmd_i);
  assign op_o  = d.op;
  assign opt_o = d.opt;
endmodule

// File: rtl/hcif_cfg_regs.sv
module hcif_cfg_regs
  import hcif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  op_e               op_i,
  input  logic [OPT_AW-1:0] opt_i,
  input  logic [6:0]        arg_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_i) begin
      case (op_i)
        OP_PAGE:     cfg_q.page     <= arg_i[2:0];
        OP_CONTRAST: cfg_q.contrast <= arg_i[3:0];
        OP_COLUMN:   cfg_q.column   <= arg_i;
        OP_SCROLL:   cfg_q.scroll   <= arg_i[4:0];
        OP_ICON:     cfg_q.icons[arg_i[2:1]] <= arg_i[0];
        OP_ICON_CTR: cfg_q.ictr     <= arg_i[1:0];
        OP_OPT:      cfg_q.opts[opt_i] <= arg_i[0];
        OP_STEP:     cfg_q.contrast <= contrast_step(cfg_q.contrast, arg_i[0]);
        default:     cfg_q <= cfg_q;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hcif_host_port.sv
module hcif_host_port
  import hcif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_strobe,
  input  logic       hst_en,
  input  logic       hst_dsel,
  input  logic       hst_rd,
  input  logic [7:0] hst_din,
  output logic [7:0] hst_dout,
  output logic       hst_oe,
  input  logic [7:0] ram_rd_byte,
  output logic       ram_wr_req,
  output logic [7:0] ram_wr_byte,
  output logic       ram_rd_req,
  output logic       clr_main_req,
  output logic       clr_icon_req,
  output logic       col_save_req,
  output logic       col_restore_req,
  output logic [2:0] page_sel,
  output logic [6:0] column_sel,
  output logic [4:0] scroll_val,
  output logic [3:0] contrast_lvl,
  output logic [3:0] icon_on,
  output logic [1:0] icon_contrast,
  output logic       pump_doubler,
  output logic       col_mirror,
  output logic       row_mirror,
  output logic       display_on,
  output logic       dcdc_on,
  output logic       regulator_on,
  output logic       divider_on,
  output logic       contrast_ctl_on,
  output logic       clk_fast,
  output logic       bias_fifth,
  output logic       duty_half,
  output logic       osc_on
);
  localparam logic [3:0] READ_TAG = 4'b0001;

  logic              fall_s, en_s, dsel_s, rd_s;
  logic [BYTE_W-1:0] din_s;
  op_e               op_w;
  logic [OPT_AW-1:0] opt_w;
  cfg_t              cfg;
  logic [CFG_W-1:0]  cfg_bits;

  // named events for the checker
  logic xfer_evt, cmd_wr_evt, data_wr_evt, data_rd_evt, step_evt, step_up;

  hcif_strobe_sync #(.STAGES(SYNC_STAGES), .W(BYTE_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(hst_strobe), .en_i(hst_en),
    .dsel_i(hst_dsel), .rd_i(hst_rd), .din_i(hst_din),
    .fall_o(fall_s), .en_o(en_s), .dsel_o(dsel_s), .rd_o(rd_s), .din_o(din_s)
  );

  hcif_cmd_decode u_dec (.cmd_i(din_s), .op_o(op_w), .opt_o(opt_w));

  assign xfer_evt    = fall_s & en_s;
  assign cmd_wr_evt  = xfer_evt & ~dsel_s & ~rd_s;
  assign data_wr_evt = xfer_evt &  dsel_s & ~rd_s;
  assign data_rd_evt = xfer_evt &  dsel_s &  rd_s;
  assign step_evt    = cmd_wr_evt & (op_w == OP_STEP);
  assign step_up     = din_s[0];

  hcif_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(cmd_wr_evt), .op_i(op_w),
    .opt_i(opt_w), .arg_i(din_s[6:0]), .cfg_o(cfg)
  );

  assign cfg_bits = cfg;

  // request pulses toward the RAM address controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_wr_req      <= 1'b0;
      ram_rd_req      <= 1'b0;
      ram_wr_byte     <= '0;
      clr_main_req    <= 1'b0;
      clr_icon_req    <= 1'b0;
      col_save_req    <= 1'b0;
      col_restore_req <= 1'b0;
    end else begin
      ram_wr_req      <= data_wr_evt;
      ram_rd_req      <= data_rd_evt;
      clr_main_req    <= cmd_wr_evt & (op_w == OP_CLR_MAIN);
      clr_icon_req    <= cmd_wr_evt & (op_w == OP_CLR_ICON);
      col_save_req    <= cmd_wr_evt & (op_w == OP_SAVE);
      col_restore_req <= cmd_wr_evt & (op_w == OP_RESTORE);
      if (data_wr_evt) ram_wr_byte <= din_s;
    end
  end

  // read path, driven straight from the pins
  assign hst_oe   = hst_en & hst_rd & hst_strobe;
  assign hst_dout = hst_dsel ? ram_rd_byte : {READ_TAG, cfg.contrast};

  assign page_sel        = cfg.page;
  assign column_sel      = cfg.column;
  assign scroll_val      = cfg.scroll;
  assign contrast_lvl    = cfg.contrast;
  assign icon_on         = cfg.icons;
  assign icon_contrast   = cfg.ictr;
  assign pump_doubler    = cfg.opts[OPT_DOUBLER];
  assign col_mirror      = cfg.opts[OPT_COLMIR];
  assign row_mirror      = cfg.opts[OPT_ROWMIR];
  assign display_on      = cfg.opts[OPT_DISP];
  assign dcdc_on         = cfg.opts[OPT_DCDC];
  assign regulator_on    = cfg.opts[OPT_REG];
  assign divider_on      = cfg.opts[OPT_DIV];
  assign contrast_ctl_on = cfg.opts[OPT_CCTL];
  assign clk_fast        = cfg.opts[OPT_FAST];
  assign bias_fifth      = cfg.opts[OPT_BIAS];
  assign duty_half       = cfg.opts[OPT_DUTY];
  assign osc_on          = cfg.opts[OPT_OSC];

endmodule

// File: rtl/hcif_host_port_chk.sv
module hcif_host_port_chk
  import hcif_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr_evt,
  input logic             step_evt,
  input logic             step_up,
  input logic [CFG_W-1:0] cfg_bits,
  input logic [2:0]       page_sel,
  input logic [3:0]       contrast_lvl,
  input logic             ram_wr_req,
  input logic             ram_rd_req,
  input logic             clr_main_req,
  input logic             clr_icon_req,
  input logic             col_save_req,
  input logic             col_restore_req
);
  assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_bits == CFG_W'(CFG_RESET));

  assert_cfg_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_evt |=> $stable(cfg_bits));

  assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && step_up) |=> contrast_lvl == $past(contrast_lvl) + 4'd1);

  assert_step_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !step_up) |=> contrast_lvl == $past(contrast_lvl) - 4'd1);

  assert_page_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel <= 3'd4);

  assert_req_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_wr_req, ram_rd_req, clr_main_req, clr_icon_req,
              col_save_req, col_restore_req}));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_req |=> !ram_wr_req);

  assert_wr_keeps_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_req |-> $stable(cfg_bits));

  assert_rd_keeps_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_req |-> $stable(cfg_bits));

endmodule

bind hcif_host_port hcif_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr_evt(cmd_wr_evt), .step_evt(step_evt),
  .step_up(step_up), .cfg_bits(cfg_bits), .page_sel(page_sel),
  .contrast_lvl(contrast_lvl), .ram_wr_req(ram_wr_req), .ram_rd_req(ram_rd_req),
  .clr_main_req(clr_main_req), .clr_icon_req(clr_icon_req),
  .col_save_req(col_save_req), .col_restore_req(col_restore_req)
);

// File: tb/sim_hcif_host_port.sv
module sim_hcif_host_port;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_strobe = 1'b0, hst_en = 1'b0, hst_dsel = 1'b0, hst_rd = 1'b0;
  logic [7:0] hst_din = 8'h00, ram_rd_byte = 8'h00;
  logic [7:0] hst_dout, ram_wr_byte;
  logic hst_oe, ram_wr_req, ram_rd_req, clr_main_req, clr_icon_req;
  logic col_save_req, col_restore_req;
  logic [2:0] page_sel;
  logic [6:0] column_sel;
  logic [4:0] scroll_val;
  logic [3:0] contrast_lvl, icon_on;
  logic [1:0] icon_contrast;
  logic pump_doubler, col_mirror, row_mirror, display_on, dcdc_on, regulator_on;
  logic divider_on, contrast_ctl_on, clk_fast, bias_fifth, duty_half, osc_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the configuration
  logic [2:0]  e_page;
  logic [3:0]  e_con;
  logic [6:0]  e_col;
  logic [4:0]  e_scr;
  logic [3:0]  e_icon;
  logic [1:0]  e_ictr;
  logic [11:0] e_opts;

  // values captured by one host cycle
  logic       c_oe;
  logic [7:0] c_dout;
  logic [5:0] c_req;   // {wr, rd, clr_main, clr_icon, save, restore}

  always #(PERIOD/2) clk = ~clk;

  hcif_host_port u0 (.*);

  function automatic logic [7:0] opt_code(input int i);
    case (i)
      0: return 8'h20;  1: return 8'h22;  2: return 8'h24;  3: return 8'h28;
      4: return 8'h2A;  5: return 8'h2C;  6: return 8'h2E;  7: return 8'h30;
      8: return 8'h32;  9: return 8'h38; 10: return 8'h68;
      default: return 8'h7E;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    logic [36:0] act, exp;
    act = {page_sel, contrast_lvl, column_sel, scroll_val, icon_on, icon_contrast,
           osc_on, duty_half, bias_fifth, clk_fast, contrast_ctl_on, divider_on,
           regulator_on, dcdc_on, display_on, row_mirror, col_mirror, pump_doubler};
    exp = {e_page, e_con, e_col, e_scr, e_icon, e_ictr, e_opts};
    chk(req, 64'(act), 64'(exp));
  endtask

  // one strobe pulse; bus sampled mid-pulse, requests sampled after sync latency
  task automatic host_cycle(input logic dsel, input logic rd, input logic en,
                            input logic [7:0] b);
    @(negedge clk);
    hst_dsel = dsel; hst_rd = rd; hst_en = en; hst_din = b; hst_strobe = 1'b1;
    repeat (3) @(negedge clk);
    c_oe = hst_oe; c_dout = hst_dout;
    hst_strobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    c_req = {ram_wr_req, ram_rd_req, clr_main_req, clr_icon_req, col_save_req,
             col_restore_req};
    @(negedge clk);
    chk("R12 pulse width", 64'({ram_wr_req, ram_rd_req, clr_main_req, clr_icon_req,
        col_save_req, col_restore_req}), 64'd0);
    hst_en = 1'b0; hst_rd = 1'b0; hst_dsel = 1'b0; hst_din = 8'h00;
  endtask

  task automatic cmd(input logic [7:0] b);
    host_cycle(1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic t_reset;
    e_page = 0; e_con = 0; e_col = 0; e_scr = 0; e_icon = 0; e_ictr = 2'b10; e_opts = 0;
    chk_cfg("R1 reset config");
    chk("R1 reset requests", 64'({ram_wr_req, ram_rd_req, clr_main_req, clr_icon_req,
        col_save_req, col_restore_req}), 64'd0);
    chk("R1 reset oe", 64'(hst_oe), 64'd0);
  endtask

  task automatic t_enable_gate;
    host_cycle(1'b0, 1'b0, 1'b0, 8'h1A);
    chk_cfg("R2 enable low ignored");
    chk("R2 enable low no request", 64'(c_req), 64'd0);
    cmd(8'h1A); e_con = 4'hA;
    chk_cfg("R2 R8 contrast set with enable");
  endtask

  task automatic t_page;
    cmd(8'h03); e_page = 3; chk_cfg("R7 page 3");
    cmd(8'h04); e_page = 4; chk_cfg("R7 page 4");
    for (int p = 5; p < 8; p++) begin
      cmd(8'(p)); chk_cfg("R7 page code above 4 ignored");
    end
  endtask

  task automatic t_contrast;
    cmd(8'h1F); e_con = 4'hF; chk_cfg("R8 contrast 15");
    cmd(8'h71); e_con = 4'h0; chk_cfg("R8 step up wraps to 0");
    cmd(8'h70); e_con = 4'hF; chk_cfg("R8 step down wraps to 15");
    cmd(8'h70); e_con = 4'hE; chk_cfg("R8 step down");
    cmd(8'h71); e_con = 4'hF; chk_cfg("R8 step up");
  endtask

  task automatic t_column_scroll;
    cmd(8'hC5); e_col = 7'h45; chk_cfg("R9 column");
    cmd(8'hFF); e_col = 7'h7F; chk_cfg("R9 column max");
    cmd(8'h5B); e_scr = 5'h1B; chk_cfg("R9 scroll");
  endtask

  task automatic t_icons;
    cmd(8'h65); e_icon[2] = 1'b1; chk_cfg("R10 icon 2 on");
    cmd(8'h61); e_icon[0] = 1'b1; chk_cfg("R10 icon 0 on");
    cmd(8'h67); e_icon[3] = 1'b1; chk_cfg("R10 icon 3 on");
    cmd(8'h64); e_icon[2] = 1'b0; chk_cfg("R10 icon 2 off");
    cmd(8'h0F); e_ictr = 2'b11; chk_cfg("R10 icon contrast 3");
    cmd(8'h0C); e_ictr = 2'b00; chk_cfg("R10 icon contrast 0");
  endtask

  task automatic t_options;
    for (int i = 0; i < 12; i++) begin
      cmd(opt_code(i) | 8'h01); e_opts[i] = 1'b1; chk_cfg("R11 option set");
    end
    for (int i = 0; i < 12; i += 2) begin
      cmd(opt_code(i)); e_opts[i] = 1'b0; chk_cfg("R11 option clear");
    end
  endtask

  task automatic t_requests;
    cmd(8'h36); chk("R12 clear main", 64'(c_req), 64'b001000); chk_cfg("R12 cfg");
    cmd(8'h37); chk("R12 clear icon", 64'(c_req), 64'b000100);
    cmd(8'h35); chk("R12 save column", 64'(c_req), 64'b000010);
    cmd(8'h34); chk("R12 restore column", 64'(c_req), 64'b000001);
  endtask

  task automatic t_reserved;
    logic [7:0] rsv [10] = '{8'h26, 8'h27, 8'h3A, 8'h3B, 8'h3C, 8'h3E, 8'h3F,
                             8'h6A, 8'h72, 8'h08};
    for (int k = 0; k < 10; k++) begin
      cmd(rsv[k]);
      chk_cfg("R13 reserved keeps config");
      chk("R13 reserved no request", 64'(c_req), 64'd0);
    end
  endtask

  task automatic t_data_write;
    host_cycle(1'b1, 1'b0, 1'b1, 8'hA5);
    chk("R3 write request", 64'(c_req), 64'b100000);
    chk("R3 write byte", 64'(ram_wr_byte), 64'hA5);
    chk_cfg("R3 config untouched");
    chk("R5 no drive on write", 64'(c_oe), 64'd0);
  endtask

  task automatic t_data_read;
    ram_rd_byte = 8'h3C;
    host_cycle(1'b1, 1'b1, 1'b1, 8'hFF);
    chk("R4 read drive", 64'(c_oe), 64'd1);
    chk("R4 read byte", 64'(c_dout), 64'h3C);
    chk("R4 read request", 64'(c_req), 64'b010000);
    chk_cfg("R4 config untouched");
    chk("R5 released after read", 64'(hst_oe), 64'd0);
    host_cycle(1'b1, 1'b1, 1'b0, 8'hFF);
    chk("R5 enable low no drive", 64'(c_oe), 64'd0);
    chk("R2 enable low no read request", 64'(c_req), 64'd0);
  endtask

  task automatic t_cmd_read;
    cmd(8'h16); e_con = 4'h6;
    host_cycle(1'b0, 1'b1, 1'b1, 8'h10);
    chk("R6 contrast readback", 64'(c_dout), 64'h16);
    chk("R6 drive", 64'(c_oe), 64'd1);
    chk_cfg("R6 read keeps config");
    chk("R6 no request", 64'(c_req), 64'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_enable_gate;
    t_page;
    t_contrast;
    t_column_scroll;
    t_icons;
    t_options;
    t_requests;
    t_reserved;
    t_data_write;
    t_data_read;
    t_cmd_read;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule